// File: doc/BRIEF.md
# Multi-byte count readout sequencer

This block lets a host processor collect a held multi-byte count one byte at a time. It uses one read strobe and one shared byte-wide data bus. An internal slot pointer picks which byte source may drive the bus. Slot 0 is a status byte that carries the count-valid flag and the top nibble of the count. Slots 1 and 2 carry the middle byte and the low byte.

The host raises the strobe and takes the byte. When the host releases the strobe, the pointer steps to the next slot and the bus goes idle. If the status byte shows the count is not yet valid, the host stops there and clears the pointer. It polls again later. If the count is valid, the host reads the next two bytes and then clears the pointer. The count and the valid flag are captured when the status read begins. All three bytes of one pass therefore describe the same count.

The bus is modelled as an enable plus a data bus that reads zero while idle, not as a true tri-state net.

Top module: `byte_readout_seq`

## Requirements
- R1: While `rst_n` is sampled low, and after it, until the first strobe, `bus_en` is 0, `bus_data` is 0 and the pointer is at slot 0. This holds even if reset arrives in the middle of a strobe.
- R2: `bus_en` rises in the cycle after the clock edge that first samples `rd_strobe` high, provided the pointer is on a slot from 0 to 2. It stays high while the strobe stays high.
- R3: The slot 0 byte is {valid, 3'b000, count[19:16]}: the valid flag is in bit 7 and count bits 19..16 are in bits 3..0.
- R4: The slot 1 byte is count[15:8] and the slot 2 byte is count[7:0]. They are read in that order after slot 0.
- R5: An edge that samples `rd_strobe` low after it was high advances the pointer by one slot. In the following cycle `bus_en` is 0 and `bus_data` is 0.
- R6: The count and the valid flag are captured at the strobe edge that starts a slot 0 read. Changes to `cnt_valid` or `count_in` after that edge have no effect on the bytes of the same pass.
- R7: Once all three slots have been released, later strobes leave `bus_en` at 0 and `bus_data` at 0 until the pointer is cleared.
- R8: An edge that samples `ptr_clear` high puts the pointer on slot 0. If a strobe release falls on the same edge, the clear wins.
- R9: `bus_data` is 0 in every cycle in which `bus_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_strobe | input | 1 | Host read strobe; held high for one byte access |
| ptr_clear | input | 1 | Host command that returns the pointer to slot 0 |
| cnt_valid | input | 1 | Count-complete flag |
| count_in | input | 20 | Held count value |
| bus_en | output | 1 | High while the selected byte source drives the bus |
| bus_data | output | 8 | Selected byte, zero while idle |

## Verification
A strobe release and a pointer clear can land on the same clock edge. One would advance the pointer and the other would send it back to slot 0. The bench provokes this by dropping the strobe and raising the clear in the same cycle. It then checks that the bus goes idle and that the next read returns the status byte, not the middle byte. The count used here is chosen so that those two bytes differ. A second overlap is a reset that arrives while a strobe is held. The next read must still start from slot 0.

// File: rtl/brs_pkg.sv
// Package: defaults shared by the readout sequencer and its checker.
// Assumes: the count plus one valid bit fits in the slot bytes.
package brs_pkg;
    parameter int BRS_BYTE_W  = 8;
    parameter int BRS_CNT_W   = 20;
    parameter int BRS_N_SLOTS = 3;
endpackage

// File: rtl/brs_slot_ptr.sv
// Slot pointer: registers the strobe, steps the slot on each release and
// saturates one past the last slot. A clear returns the pointer to slot 0
// and takes priority over a release on the same edge.
// Assumes: rd_strobe and ptr_clear are synchronous to clk.
module brs_slot_ptr #(
    parameter int N_SLOTS = 3,
    parameter int PTR_W   = $clog2(N_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_strobe,
    input  logic             ptr_clear,
    output logic [PTR_W-1:0] slot,
    output logic             strb_q,
    output logic             strb_rise
);
    localparam logic [PTR_W-1:0] DONE = PTR_W'(N_SLOTS);

    // Pointer and strobe history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot   <= '0;
            strb_q <= 1'b0;
        end else begin
            strb_q <= rd_strobe;
            if (ptr_clear)
                slot <= '0;
            else if (strb_q && !rd_strobe && slot != DONE)
                slot <= slot + 1'b1;
        end
    end

    // Rising strobe edge relative to the last sampled value.
    always_comb strb_rise = rd_strobe && !strb_q;
endmodule

// File: rtl/brs_snapshot.sv
// Snapshot: captures {valid, zero pad, count} into one word on load.
// Assumes: WORD_W >= CNT_W + 1; the valid flag goes to the top bit.
module brs_snapshot #(
    parameter int CNT_W  = 20,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cnt_valid,
    input  logic [CNT_W-1:0]  count_in,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] packed_w;

    // Pack valid into the top bit and the count into the low bits.
    always_comb begin
        packed_w              = '0;
        packed_w[CNT_W-1:0]   = count_in;
        packed_w[WORD_W-1]    = cnt_valid;
    end

    // Hold the packed word until the next slot-0 read starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word <= '0;
        else if (load)
            word <= packed_w;
    end
endmodule

// File: rtl/brs_byte_mux.sv
// Byte selector: enables exactly one slot source while the registered
// strobe is high and the pointer is on a real slot; drives zero otherwise.
// Assumes: slot 0 is the most significant byte of the word.
module brs_byte_mux #(
    parameter int N_SLOTS = 3,
    parameter int BYTE_W  = 8,
    parameter int PTR_W   = $clog2(N_SLOTS + 1),
    parameter int WORD_W  = N_SLOTS * BYTE_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [PTR_W-1:0]  slot,
    input  logic              strb_q,
    output logic              bus_en,
    output logic [BYTE_W-1:0] bus_data
);
    localparam logic [PTR_W-1:0] DONE = PTR_W'(N_SLOTS);

    logic [BYTE_W-1:0] slice [N_SLOTS];
    logic [N_SLOTS-1:0] sel;

    // One source slice and one select line per slot.
    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        assign slice[k] = word[WORD_W-1-k*BYTE_W -: BYTE_W];
        assign sel[k]   = strb_q && (slot == PTR_W'(k));
    end

    // Enable and AND-OR data selection; zero when nothing is selected.
    always_comb begin
        bus_en   = strb_q && (slot != DONE);
        bus_data = '0;
        for (int k = 0; k < N_SLOTS; k++)
            if (sel[k])
                bus_data = bus_data | slice[k];
    end
endmodule

// File: rtl/byte_readout_seq.sv
// Top: byte-serial readout of a held count through one strobe and a shared
// byte bus. Slot 0 returns status (valid + top nibble), then the middle and
// low count bytes. Releases step the slot; the host clears it afterwards.
// Assumes: the host holds the strobe for at least one clock per byte.
module byte_readout_seq #(
    parameter int BYTE_W  = brs_pkg::BRS_BYTE_W,
    parameter int CNT_W   = brs_pkg::BRS_CNT_W,
    parameter int N_SLOTS = brs_pkg::BRS_N_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              ptr_clear,
    input  logic              cnt_valid,
    input  logic [CNT_W-1:0]  count_in,
    output logic              bus_en,
    output logic [BYTE_W-1:0] bus_data
);
    localparam int PTR_W  = $clog2(N_SLOTS + 1);
    localparam int WORD_W = N_SLOTS * BYTE_W;

    logic [PTR_W-1:0]  slot;
    logic              strb_q;
    logic              strb_rise;
    logic              snap_load;
    logic [WORD_W-1:0] snap_word;

    brs_slot_ptr #(.N_SLOTS(N_SLOTS), .PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .ptr_clear(ptr_clear),
        .slot(slot), .strb_q(strb_q), .strb_rise(strb_rise)
    );

    // Capture the count at the start of a status read.
    always_comb snap_load = strb_rise && (slot == '0);

    brs_snapshot #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .load(snap_load), .cnt_valid(cnt_valid),
        .count_in(count_in), .word(snap_word)
    );

    brs_byte_mux #(.N_SLOTS(N_SLOTS), .BYTE_W(BYTE_W), .PTR_W(PTR_W), .WORD_W(WORD_W)) u_mux (
        .word(snap_word), .slot(slot), .strb_q(strb_q),
        .bus_en(bus_en), .bus_data(bus_data)
    );
endmodule

// File: rtl/brs_readout_chk.sv
// Checker: temporal properties of the readout sequencer, bound to the top.
// Assumes: slot and snap_word are the top's pointer and snapshot word.
module brs_readout_chk #(
    parameter int BYTE_W  = 8,
    parameter int N_SLOTS = 3,
    parameter int PTR_W   = 2,
    parameter int WORD_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              ptr_clear,
    input logic              bus_en,
    input logic [BYTE_W-1:0] bus_data,
    input logic [PTR_W-1:0]  slot,
    input logic [WORD_W-1:0] snap_word
);
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !bus_en |-> bus_data == '0) else $error("idle bus not zero"); // R9
    AST_EN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) bus_en |-> $past(rd_strobe)) else $error("enable without strobe"); // R2
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) ($past(rd_strobe) && !rd_strobe) |=> !bus_en) else $error("bus active after release"); // R5
    AST_CLEAR_SLOT0: assert property (@(posedge clk) disable iff (!rst_n) ptr_clear |=> slot == '0) else $error("clear did not reach slot 0"); // R8
    AST_PAST_END_OFF: assert property (@(posedge clk) disable iff (!rst_n) (slot == PTR_W'(N_SLOTS)) |-> !bus_en) else $error("bus active past last slot"); // R7
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n) (slot != '0) |=> $stable(snap_word)) else $error("snapshot changed mid pass"); // R6
    AST_STATUS_VALID_BIT: assert property (@(posedge clk) disable iff (!rst_n) (bus_en && slot == '0) |-> bus_data[BYTE_W-1] == snap_word[WORD_W-1]) else $error("status bit wrong"); // R3
endmodule

bind byte_readout_seq brs_readout_chk #(
    .BYTE_W(BYTE_W), .N_SLOTS(N_SLOTS), .PTR_W(PTR_W), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .ptr_clear(ptr_clear),
    .bus_en(bus_en), .bus_data(bus_data), .slot(slot), .snap_word(snap_word)
);

// File: tb/tb_byte_readout_seq.sv
// Bench: vector table of {valid, count} walked by one loop, then directed
// tests for reset, clear/release overlap and strobe latency.
module tb_byte_readout_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_strobe = 1'b0;
    logic        ptr_clear = 1'b0;
    logic        cnt_valid = 1'b0;
    logic [19:0] count_in = '0;
    logic        bus_en;
    logic [7:0]  bus_data;
    int checks = 0;
    int errors = 0;

    localparam int NV = 6;
    localparam logic [20:0] VEC [NV] = '{21'h1ABCDE, 21'h012345, 21'h100000,
                                         21'h1FFFFF, 21'h0FFFFF, 21'h15A3C9};

    always #5 clk = ~clk;

    byte_readout_seq dut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .ptr_clear(ptr_clear),
        .cnt_valid(cnt_valid), .count_in(count_in), .bus_en(bus_en), .bus_data(bus_data)
    );

    // Expected byte for slot k: word {v, 000, count}, slot 0 most significant.
    function automatic logic [7:0] exp_byte(logic v, logic [19:0] c, int k);
        logic [23:0] w;
        w = {v, 3'b000, c};
        return w[23-8*k -: 8];
    endfunction

    task automatic check(string tag, logic ee, logic [7:0] ed);
        checks++;
        if (bus_en !== ee || bus_data !== ed) begin
            errors++;
            $display("FAIL %s: en=%0b data=%02h expected en=%0b data=%02h",
                     tag, bus_en, bus_data, ee, ed);
        end
    endtask

    // One strobe access: check the byte while held, then idle after release.
    task automatic read_slot(string tag, logic ee, logic [7:0] ed);
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) check(tag, ee, ed);
        rd_strobe = 1'b0;
        @(negedge clk) check({tag, " / R5 idle after release"}, 1'b0, 8'h00);
    endtask

    task automatic do_clear();
        @(negedge clk) ptr_clear = 1'b1;
        @(negedge clk) ptr_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: en=%0b data=%02h expected run to end", bus_en, bus_data);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic        v;
        logic [19:0] c;
        rd_strobe = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 8'h00);
        rd_strobe = 1'b0;
        rst_n = 1'b1;
        @(negedge clk) check("R1 after reset", 1'b0, 8'h00);

        // Table walk: status, then (if valid) middle, low and a past-end read.
        for (int i = 0; i < NV; i++) begin
            v = VEC[i][20];
            c = VEC[i][19:0];
            cnt_valid = v;
            count_in  = c;
            read_slot("R3 status byte", 1'b1, exp_byte(v, c, 0));
            cnt_valid = ~v;
            count_in  = ~c;
            if (v) begin
                read_slot("R4 R6 middle byte", 1'b1, exp_byte(v, c, 1));
                read_slot("R4 R6 low byte", 1'b1, exp_byte(v, c, 2));
                read_slot("R7 past end", 1'b0, 8'h00);
                read_slot("R7 past end again", 1'b0, 8'h00);
            end
            do_clear();
        end

        // R2: no enable before the strobe is sampled, enable one cycle later.
        c = 20'hA5C3E;
        cnt_valid = 1'b1;
        count_in  = c;
        @(negedge clk) rd_strobe = 1'b1;
        #1 check("R2 no early enable", 1'b0, 8'h00);
        @(negedge clk) check("R2 enable after strobe", 1'b1, exp_byte(1'b1, c, 0));
        @(negedge clk) check("R2 enable held", 1'b1, exp_byte(1'b1, c, 0));

        // R8: release and clear on the same edge; clear must win.
        rd_strobe = 1'b0;
        ptr_clear = 1'b1;
        @(negedge clk) ptr_clear = 1'b0;
        check("R8 idle after overlap", 1'b0, 8'h00);
        read_slot("R8 clear wins over release", 1'b1, exp_byte(1'b1, c, 0));

        // R8: clear in mid-sequence restarts at status.
        read_slot("R4 middle before clear", 1'b1, exp_byte(1'b1, c, 1));
        do_clear();
        read_slot("R8 restart at status", 1'b1, exp_byte(1'b1, c, 0));

        // R1: reset during a held strobe ends the access and rewinds.
        do_clear();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) check("R1 reset during strobe", 1'b0, 8'h00);
        rd_strobe = 1'b0;
        rst_n = 1'b1;
        c = 20'h3B7D1;
        count_in = c;
        read_slot("R1 rewind to status", 1'b1, exp_byte(1'b1, c, 0));
        read_slot("R4 middle after reset", 1'b1, exp_byte(1'b1, c, 1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule